// File: doc/BRIEF.md
# Entropy Health Gate and Sample Pairer

This block sits between a raw entropy source and a seed conditioner. Raw entropy arrives as wide samples on a valid/ready stream. Each accepted sample is screened on its own: the number of ones it contains and its longest run of equal bits are compared against fixed limits. The pass or fail result goes into a sliding window that covers the most recent accepted samples. A running count tracks how many samples in that window passed.

After reset the block is on probation. It consumes one full window of samples and releases nothing. When the last sample of that window arrives, the block judges the count. If the count is at or above the threshold, the block starts running. If not, it fails. While running, only samples that passed the screen are gathered, two at a time, into a pair, and each complete pair goes out on a second valid/ready stream to the conditioner. If the window count ever drops below the threshold, the block fails for good: it throws away any half-built pair, stops taking input and never releases another pair until reset.

Back-pressure follows these rules. The block can hold one complete pair. While that pair waits, the block accepts no new sample, unless the consumer takes the pair in the same cycle. In that case one pair leaves and one sample enters on the same clock edge.

Top module: `entropy_health_gate`

## Requirements
- R1: A sample passes the screen only if its count of ones is within [ONES_LO, ONES_HI] and its longest run of identical adjacent bits is at most MAX_RUN. A sample that fails the screen never appears in a pair.
- R2: The window count is the number of passing samples among the last WIN_DEPTH accepted samples. An old result stops counting once WIN_DEPTH newer samples have been accepted.
- R3: After reset, `healthy` and `failed` are low. On the WIN_DEPTH-th accepted sample, the count including that sample is judged. From the next cycle, `healthy` is high if the count is at least WIN_MIN, and `failed` is high otherwise. `healthy` and `failed` are never high together.
- R4: While running, if an accepted sample brings the window count below WIN_MIN, then from the next cycle `failed` is high and `healthy` is low. Any half-built pair is discarded, and `failed` stays high until reset.
- R5: Only passing samples accepted while running fill pairs. Samples accepted during probation are never paired. In `pair_data`, bits [SAMPLE_W-1:0] hold the earlier sample and the upper half holds the later one.
- R6: `pair_valid` is high only while `healthy` is high. Once raised, `pair_valid` stays high with `pair_data` unchanged until the cycle in which `pair_ready` is high.
- R7: `smp_ready` is high exactly when the block has not failed and either no complete pair is held or `pair_ready` is high. A pair release and a sample acceptance can therefore happen on the same edge.
- R8: After a failure, `smp_ready` and `pair_valid` stay low.
- R9: While `rst_n` is low and in the first cycle after it, `pair_valid` is low and `smp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Raw sample offered |
| smp_ready | output | 1 | Block takes the raw sample this cycle |
| smp_data | input | SAMPLE_W | Raw entropy sample |
| pair_valid | output | 1 | Complete pair of passing samples offered |
| pair_ready | input | 1 | Conditioner takes the pair this cycle |
| pair_data | output | 2*SAMPLE_W | Pair; earlier sample in the low half |
| healthy | output | 1 | Probation passed and no failure |
| failed | output | 1 | Sticky failure indication |

## Verification
The critical coincidence is a pair release and a new sample acceptance on the same edge. The sharpest form is when that new sample fails the screen and drops the window count below the threshold. The bench builds this case. It holds `pair_ready` low until a pair is complete, arranges the window count to sit exactly at WIN_MIN, and then raises `pair_ready` while it offers a failing sample. It then checks three things: `smp_ready` was high in that cycle, the held pair was delivered intact, and the block reports a failure from the next cycle with no further pairs. A long sweep with a stuttering `pair_ready` makes release and intake overlap many more times, and each delivered pair is compared with an arithmetic model of the screen and window.

// File: rtl/hg_pkg.sv
package hg_pkg;

  typedef enum logic [1:0] {
    HG_PROBE = 2'd0,
    HG_RUN   = 2'd1,
    HG_FAIL  = 2'd2
  } hg_state_e;

endpackage

// File: rtl/hg_sample_screen.sv
module hg_sample_screen #(
  parameter int SAMPLE_W = 256,
  parameter int MAX_RUN  = 34,
  parameter int ONES_LO  = 100,
  parameter int ONES_HI  = 156
) (
  input  logic [SAMPLE_W-1:0] data,
  output logic                pass
);
  localparam int CW = $clog2(SAMPLE_W + 1);
  localparam logic [CW-1:0] LO_V  = CW'(ONES_LO);
  localparam logic [CW-1:0] HI_V  = CW'(ONES_HI);
  localparam logic [CW-1:0] RUN_V = CW'(MAX_RUN);

  logic [CW-1:0] ones;
  logic [CW-1:0] run;
  logic [CW-1:0] best;

  always_comb begin
    ones = CW'(data[0]);
    run  = CW'(1);
    best = CW'(1);
    for (int i = 1; i < SAMPLE_W; i++) begin
      ones = ones + CW'(data[i]);
      if (data[i] == data[i-1]) run = run + CW'(1);
      else                      run = CW'(1);
      if (run > best) best = run;
    end
  end

  assign pass = (ones >= LO_V) && (ones <= HI_V) && (best <= RUN_V);

endmodule

// File: rtl/hg_window.sv
module hg_window #(
  parameter int WIN_DEPTH = 256,
  parameter int WIN_MIN   = 224
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             pass,
  output hg_pkg::hg_state_e state,
  output logic             fail_now,
  output logic             store_ok
);
  import hg_pkg::*;

  localparam int CNTW = $clog2(WIN_DEPTH + 1);
  localparam logic [CNTW-1:0] MIN_V  = CNTW'(WIN_MIN);
  localparam logic [CNTW-1:0] LAST_V = CNTW'(WIN_DEPTH - 1);

  logic [WIN_DEPTH-1:0] flags;
  logic [CNTW-1:0]      cnt;
  logic [CNTW-1:0]      cnt_nxt;
  logic [CNTW-1:0]      seen;
  logic                 below;
  logic                 last_probe;

  assign cnt_nxt    = cnt + CNTW'(pass) - CNTW'(flags[WIN_DEPTH-1]);
  assign below      = cnt_nxt < MIN_V;
  assign last_probe = (state == HG_PROBE) && (seen == LAST_V);
  assign fail_now   = accept && below && ((state == HG_RUN) || last_probe);
  assign store_ok   = accept && (state == HG_RUN) && pass && !below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      cnt   <= '0;
      seen  <= '0;
      state <= HG_PROBE;
    end else if (accept && (state != HG_FAIL)) begin
      flags <= {flags[WIN_DEPTH-2:0], pass};
      cnt   <= cnt_nxt;
      if (state == HG_PROBE) begin
        seen <= seen + CNTW'(1);
        if (last_probe) state <= below ? HG_FAIL : HG_RUN;
      end else if (below) begin
        state <= HG_FAIL;
      end
    end
  end

endmodule

// File: rtl/hg_pair_buf.sv
module hg_pair_buf #(
  parameter int SAMPLE_W = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic                  pop,
  input  logic                  clear,
  input  logic [SAMPLE_W-1:0]   din,
  output logic                  full,
  output logic [2*SAMPLE_W-1:0] dout
);
  logic [SAMPLE_W-1:0] lo_q;
  logic [SAMPLE_W-1:0] hi_q;
  logic [1:0]          fill;
  logic [1:0]          base;

  assign base = pop ? 2'd0 : fill;
  assign full = (fill == 2'd2);
  assign dout = {hi_q, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      fill <= 2'd0;
    end else if (clear) begin
      fill <= 2'd0;
    end else if (push) begin
      if (base == 2'd0) lo_q <= din;
      else              hi_q <= din;
      fill <= base + 2'd1;
    end else if (pop) begin
      fill <= 2'd0;
    end
  end

endmodule

// File: rtl/entropy_health_gate.sv
module entropy_health_gate #(
  parameter int SAMPLE_W  = 256,
  parameter int WIN_DEPTH = 256,
  parameter int WIN_MIN   = 224,
  parameter int MAX_RUN   = 34,
  parameter int ONES_LO   = 100,
  parameter int ONES_HI   = 156
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_valid,
  output logic                  smp_ready,
  input  logic [SAMPLE_W-1:0]   smp_data,
  output logic                  pair_valid,
  input  logic                  pair_ready,
  output logic [2*SAMPLE_W-1:0] pair_data,
  output logic                  healthy,
  output logic                  failed
);
  import hg_pkg::*;

  hg_state_e state;
  logic      pass;
  logic      accept;
  logic      fail_now;
  logic      store_ok;
  logic      full;
  logic      pop;

  assign failed     = (state == HG_FAIL);
  assign healthy    = (state == HG_RUN);
  assign smp_ready  = !failed && (!full || pair_ready);
  assign accept     = smp_valid && smp_ready;
  assign pair_valid = full && healthy;
  assign pop        = pair_valid && pair_ready;

  hg_sample_screen #(
    .SAMPLE_W(SAMPLE_W),
    .MAX_RUN (MAX_RUN),
    .ONES_LO (ONES_LO),
    .ONES_HI (ONES_HI)
  ) u_screen (
    .data(smp_data),
    .pass(pass)
  );

  hg_window #(
    .WIN_DEPTH(WIN_DEPTH),
    .WIN_MIN  (WIN_MIN)
  ) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .pass    (pass),
    .state   (state),
    .fail_now(fail_now),
    .store_ok(store_ok)
  );

  hg_pair_buf #(
    .SAMPLE_W(SAMPLE_W)
  ) u_pair (
    .clk  (clk),
    .rst_n(rst_n),
    .push (store_ok),
    .pop  (pop),
    .clear(fail_now),
    .din  (smp_data),
    .full (full),
    .dout (pair_data)
  );

endmodule

// File: rtl/hg_checker.sv
module hg_checker #(
  parameter int PAIR_W = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic              pair_valid,
  input logic              pair_ready,
  input logic [PAIR_W-1:0] pair_data,
  input logic              healthy,
  input logic              failed
);

  assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(healthy && failed));

  assert_probe_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(healthy) |-> $past(smp_valid && smp_ready));

  assert_fail_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    failed |=> failed);

  assert_pair_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> healthy);

  assert_pair_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && !pair_ready) |=> (pair_valid && $stable(pair_data)));

  assert_same_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && pair_ready) |-> smp_ready);

  assert_no_intake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    failed |-> (!smp_ready && !pair_valid));

endmodule

bind entropy_health_gate hg_checker #(.PAIR_W(2*SAMPLE_W)) u_hg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .pair_valid(pair_valid),
  .pair_ready(pair_ready),
  .pair_data (pair_data),
  .healthy   (healthy),
  .failed    (failed)
);

// File: tb/entropy_health_gate_test.sv
`timescale 1ns/1ps
module entropy_health_gate_test;
  localparam int SW = 16, WD = 8, WM = 6, MR = 4, OL = 6, OH = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_valid = 1'b0;
  logic          smp_ready;
  logic [SW-1:0] smp_data = '0;
  logic          pair_valid;
  logic          pair_ready = 1'b0;
  logic [2*SW-1:0] pair_data;
  logic          healthy;
  logic          failed;

  int checks = 0;
  int errors = 0;

  // model state
  logic [WD-1:0] mwin;
  int            mcnt, macc, mstate, mslot_n;
  logic [SW-1:0] mslot0;
  logic [2*SW-1:0] expq [0:255];
  int            wr = 0, rd = 0;

  bit   rdy_mode = 1'b0;
  bit   man_rdy  = 1'b0;
  int   cyc = 0;

  always #2 clk = ~clk;

  entropy_health_gate #(
    .SAMPLE_W(SW), .WIN_DEPTH(WD), .WIN_MIN(WM),
    .MAX_RUN(MR), .ONES_LO(OL), .ONES_HI(OH)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .pair_valid(pair_valid), .pair_ready(pair_ready), .pair_data(pair_data),
    .healthy(healthy), .failed(failed)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic bit screen(input logic [SW-1:0] x);
    int ones = 0, run = 1, best = 1;
    for (int i = 0; i < SW; i++) ones += int'(x[i]);
    for (int i = 1; i < SW; i++) begin
      run = (x[i] == x[i-1]) ? run + 1 : 1;
      if (run > best) best = run;
    end
    return (ones >= OL) && (ones <= OH) && (best <= MR);
  endfunction

  task automatic model_reset();
    mwin = '0; mcnt = 0; macc = 0; mstate = 0; mslot_n = 0; mslot0 = '0;
    wr = 0; rd = 0;
  endtask

  task automatic model_update(input logic [SW-1:0] x);
    bit h = screen(x);
    if (mstate == 2) return;
    mcnt = mcnt + int'(h) - int'(mwin[WD-1]);
    mwin = {mwin[WD-2:0], h};
    if (mstate == 0) begin
      macc++;
      if (macc == WD) mstate = (mcnt >= WM) ? 1 : 2;
    end else if (mcnt < WM) begin
      mstate = 2; mslot_n = 0;
    end else if (h) begin
      if (mslot_n == 0) begin mslot0 = x; mslot_n = 1; end
      else begin expq[wr % 256] = {x, mslot0}; wr++; mslot_n = 0; end
    end
  endtask

  // pair_ready driver: changes just after each rising edge
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      pair_ready = rdy_mode ? man_rdy : ((cyc % 3) != 0);
    end
  end

  // consumer: a transfer seen here happens at the next rising edge
  always @(negedge clk) begin
    if (rst_n && failed && pair_valid)
      chk(1'b0, "R8 pair offered after failure", 32'(pair_valid), 32'd0);
    if (rst_n && pair_valid && pair_ready) begin
      if (rd == wr) chk(1'b0, "R5 unexpected pair", pair_data, 32'd0);
      else begin
        chk(pair_data == expq[rd % 256], "R5/R1 pair content", pair_data, expq[rd % 256]);
        rd++;
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; smp_valid = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic send(input logic [SW-1:0] x);
    @(negedge clk);
    smp_data = x; smp_valid = 1'b1;
    for (int n = 0; n < 1000; n++) begin
      if (smp_ready) break;
      @(negedge clk);
    end
    if (!smp_ready) chk(1'b0, "R7 input stalled", 32'(smp_ready), 32'd1);
    @(posedge clk);
    model_update(x);
    #1 smp_valid = 1'b0;
  endtask

  localparam logic [SW-1:0] H0 = 16'hAAAA, H1 = 16'h3333, H2 = 16'hCCCC, H3 = 16'h5555;
  localparam logic [SW-1:0] U0 = 16'h0000, U1 = 16'hFFFF, U2 = 16'hF8F0;

  task automatic fill(input int n);
    for (int k = 0; k < n; k++)
      case (k % 4) 0: send(H0); 1: send(H1); 2: send(H2); default: send(H3); endcase
  endtask

  initial begin
    logic [2*SW-1:0] held;
    // R9 reset state
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(pair_valid == 1'b0, "R9 pair_valid in reset", 32'(pair_valid), 32'd0);
    chk(smp_ready == 1'b1, "R9 smp_ready in reset", 32'(smp_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(healthy == 1'b0 && failed == 1'b0, "R3 status after reset", {healthy, failed}, 32'd0);
    chk(pair_valid == 1'b0, "R9 pair_valid after reset", 32'(pair_valid), 32'd0);

    // R3 probation failure: three bad samples in the first window
    send(U0); send(U1); send(U2);
    fill(4);
    @(negedge clk);
    chk(healthy == 1'b0 && failed == 1'b0, "R3 still on probation", {healthy, failed}, 32'd0);
    send(H0);
    @(negedge clk);
    chk(failed == 1'b1 && healthy == 1'b0, "R3 probation verdict fail", {healthy, failed}, 32'd1);
    chk(smp_ready == 1'b0, "R8 intake closed", 32'(smp_ready), 32'd0);

    // R4 running failure discards half pair
    do_reset();
    fill(8);
    @(negedge clk);
    chk(healthy == 1'b1, "R3 probation verdict pass", 32'(healthy), 32'd1);
    send(H1);
    send(U0); send(U1);
    @(negedge clk);
    chk(failed == 1'b0, "R4 at threshold", 32'(failed), 32'd0);
    send(U2);
    @(negedge clk);
    chk(failed == 1'b1 && healthy == 1'b0, "R4 drop below threshold", {healthy, failed}, 32'd1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(pair_valid == 1'b0 && smp_ready == 1'b0, "R8 silent after failure", {pair_valid, smp_ready}, 32'd0);
    end
    chk(wr == 0 && rd == 0, "R4 half pair discarded", rd, 32'd0);

    // R2 sliding window: old bad samples age out
    do_reset();
    fill(8);
    send(U0); send(U1);
    fill(8);
    send(U1); send(U0);
    @(negedge clk);
    chk(failed == 1'b0 && healthy == 1'b1, "R2 old flags left window", {healthy, failed}, 32'd2);
    send(U2);
    @(negedge clk);
    chk(failed == 1'b1, "R2 count below minimum", 32'(failed), 32'd1);
    repeat (4) @(negedge clk);
    chk(rd == wr, "R5 pairs delivered before failure", rd, wr);

    // R6/R7 hold, then release and failing intake on one edge
    do_reset();
    rdy_mode = 1'b1; man_rdy = 1'b0;
    send(H0); send(H1); send(H2); send(H3); send(U0); send(U1); send(H0); send(H1);
    @(negedge clk);
    chk(healthy == 1'b1, "R3 verdict at exact minimum", 32'(healthy), 32'd1);
    send(H2); send(H3);
    @(negedge clk);
    chk(pair_valid == 1'b1, "R5 pair complete", 32'(pair_valid), 32'd1);
    chk(smp_ready == 1'b0, "R7 full and not ready", 32'(smp_ready), 32'd0);
    chk(pair_data == {H3, H2}, "R5 pair order", pair_data, {H3, H2});
    held = pair_data;
    repeat (3) @(negedge clk);
    chk(pair_valid == 1'b1 && pair_data == held, "R6 pair held", pair_data, held);
    man_rdy = 1'b1;
    @(posedge clk);
    @(negedge clk);
    smp_data = U2; smp_valid = 1'b1;
    chk(smp_ready == 1'b1, "R7 ready during release", 32'(smp_ready), 32'd1);
    @(posedge clk);
    model_update(U2);
    #1 smp_valid = 1'b0;
    @(negedge clk);
    chk(failed == 1'b1 && pair_valid == 1'b0, "R4 fail after shared edge", {failed, pair_valid}, 32'd2);
    chk(rd == 1 && wr == 1, "R7 pair left on shared edge", rd, 32'd1);
    rdy_mode = 1'b0;

    // R1/R5 sweep with stuttering consumer
    do_reset();
    fill(8);
    send(16'hF0F0); fill(3);
    send(16'hF8F0); fill(3);
    send(16'h5550); fill(3);
    send(16'h5540); fill(3);
    send(16'h0FF0); fill(3);
    for (int i = 0; i < 4096; i++) begin
      send(SW'(i * 16'h9E37));
      fill(3);
    end
    repeat (20) @(negedge clk);
    chk(rd == wr, "R5 every pair delivered", rd, wr);
    chk(healthy == 1'b1 && failed == 1'b0, "R2 window held over sweep", {healthy, failed}, 32'd2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule